// File: doc/BRIEF.md
# Effective Address Generator with Indexing and Indirection

This unit forms the final memory address for the load, store, call and branch instructions of a 32-bit processor. When the control sequencer pulses `start`, the unit captures the instruction word and the index register value that the register file places on its second read bus. It then produces a 20-bit address from them. Register 0 is wired to zero. An index field of zero therefore means plain direct addressing, whatever value appears on the index bus.

A single indirect bit turns each of the two base modes into its indirect form. Together the index field and that bit give four modes: direct, indexed, indirect and indexed-indirect. In the two indirect modes the unit issues one memory read at the computed address, using a request/acknowledge handshake. It then uses the low 20 bits of the returned word as the final address. Indexing is always applied before indirection. In every mode, `done` rises for one cycle with the result on `eff_addr`.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done` and `mem_req` are both 0.
- R2: When `start` is seen in idle with index field instr[22:20] = 000 and indirect bit instr[26] = 0, `done` is 1 in the next cycle and `eff_addr` equals instr[19:0]. The `index_val` input has no effect.
- R3: With a nonzero index field, the base address is instr[19:0] + `index_val`[19:0], truncated to 20 bits, so the sum wraps modulo 2^20.
- R4: When `start` is seen in idle with instr[26] = 1, `mem_req` is 1 in the next cycle and `mem_addr` holds the base address. Both stay unchanged until `mem_ack` is seen, and `done` stays 0 during that time.
- R5: In the cycle after `mem_ack` is sampled high while `mem_req` is 1, `done` is 1, `mem_req` is 0 and `eff_addr` equals `mem_rdata`[19:0] as sampled with the acknowledge.
- R6: `done` lasts exactly one cycle and is never high together with `mem_req`. The unit is idle in the cycle after `done`.
- R7: A `start` pulse is ignored while the unit is busy, that is while `mem_req` or `done` is high. It does not change `mem_addr` or the final address, and it does not produce an extra `done`.
- R8: In the two non-indirect modes, `mem_req` is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation (acted on only in idle) |
| instr | input | 32 | Instruction word: [26] indirect bit, [22:20] index field, [19:0] address field |
| index_val | input | 32 | Contents of the selected index register |
| mem_req | output | 1 | Memory read request for the indirect word |
| mem_addr | output | 20 | Address of the indirect read |
| mem_ack | input | 1 | Memory read acknowledge, with data valid |
| mem_rdata | input | 32 | Word returned by memory |
| done | output | 1 | One-cycle pulse: final address valid |
| eff_addr | output | 20 | Final effective address |

## Verification
The assertions assume that memory raises `mem_ack` only while `mem_req` is high. They also assume that `instr` and `index_val` are valid in the cycle in which `start` is high. The bench drives its memory model to match: the acknowledge is returned after a programmed delay of zero to three cycles, and only while a request is pending. Stimulus values are applied only together with the start pulse. To exercise the busy path, the bench also sends deliberate start pulses with different instruction words while a request is pending and during the `done` cycle.

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int IW = 32,
  parameter int DW = 32,
  parameter int AW = 20,
  parameter int IND_BIT = 26,
  parameter int XLO = 20,
  parameter int XW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] index_val,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] eff_addr
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_FIN} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [XW-1:0] xfield;
  logic [AW-1:0] offset;
  logic [AW-1:0] base;
  logic          unused_bits;

  assign xfield = instr[XLO+XW-1:XLO];
  assign offset = (xfield == '0) ? '0 : index_val[AW-1:0];
  assign base   = instr[AW-1:0] + offset;

  assign unused_bits = ^{instr[IW-1:IND_BIT+1], instr[IND_BIT-1:XLO+XW],
                         index_val[DW-1:AW], mem_rdata[DW-1:AW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          addr_q <= base;
          st     <= instr[IND_BIT] ? S_FETCH : S_FIN;
        end
        S_FETCH: if (mem_ack) begin
          addr_q <= mem_rdata[AW-1:0];
          st     <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req  = (st == S_FETCH);
  assign mem_addr = addr_q;
  assign done     = (st == S_FIN);
  assign eff_addr = addr_q;

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
  parameter int IW = 32,
  parameter int DW = 32,
  parameter int AW = 20,
  parameter int IND_BIT = 26
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [IW-1:0] instr,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic [DW-1:0] mem_rdata,
  input logic          done,
  input logic [AW-1:0] eff_addr
);

  logic idle_go;
  assign idle_go = start && !mem_req && !done;

  AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    idle_go && !instr[IND_BIT] && instr[22:20] == 3'b000 |=> done && eff_addr == $past(instr[AW-1:0])); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && !done && $stable(mem_addr)); // R4
  AST_IND_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    idle_go && instr[IND_BIT] |=> mem_req && !done); // R4
  AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> done && !mem_req && eff_addr == $past(mem_rdata[AW-1:0])); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !mem_req); // R6
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && mem_req)); // R6
  AST_NO_REQ_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    idle_go && !instr[IND_BIT] |=> !mem_req); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && start |=> mem_req && $stable(mem_addr)); // R7

endmodule

bind ea_unit ea_unit_chk #(.IW(IW), .DW(DW), .AW(AW), .IND_BIT(IND_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .mem_rdata(mem_rdata), .done(done), .eff_addr(eff_addr)
);

// File: tb/test_ea_unit.sv
module test_ea_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] index_val = '0;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [19:0] eff_addr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ea_unit i_ea_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .index_val(index_val), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .eff_addr(eff_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [19:0] af, input logic [2:0] xf, input bit ind,
                     input logic [31:0] xv, input logic [31:0] rd, input int dly,
                     input bit poke);
    logic [19:0] exp_base;
    exp_base = af + ((xf == 3'd0) ? 20'd0 : xv[19:0]);
    @(negedge clk);
    start = 1'b1;
    instr = {5'b01100, ind, xf[2:0] ^ 3'b101, xf, af};
    index_val = xv;
    @(negedge clk);
    start = 1'b0;
    instr = $random;
    index_val = $random;
    if (!ind) begin
      check(xf == 0 ? "R2 direct done" : "R3 indexed done", {31'd0, done}, 32'd1);
      check(xf == 0 ? "R2 direct addr" : "R3 indexed addr", {12'd0, eff_addr}, {12'd0, exp_base});
      check("R8 no request", {31'd0, mem_req}, 32'd0);
    end else begin
      check("R4 request", {31'd0, mem_req}, 32'd1);
      check("R4 request addr", {12'd0, mem_addr}, {12'd0, exp_base});
      check("R4 no done", {31'd0, done}, 32'd0);
      for (int k = 0; k < dly; k++) begin
        if (poke && k == 0) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R4 hold req", {31'd0, mem_req}, 32'd1);
        check(poke ? "R7 addr after busy start" : "R4 hold addr", {12'd0, mem_addr}, {12'd0, exp_base});
      end
      mem_ack = 1'b1;
      mem_rdata = rd;
      @(negedge clk);
      mem_ack = 1'b0;
      mem_rdata = $random;
      check("R5 done", {31'd0, done}, 32'd1);
      check("R5 final addr", {12'd0, eff_addr}, {12'd0, rd[19:0]});
      check("R5 req dropped", {31'd0, mem_req}, 32'd0);
    end
    if (poke) begin
      start = 1'b1;
      instr = {5'b01100, 1'b0, 6'd0, 20'h12345};
    end
    @(negedge clk);
    start = 1'b0;
    check(poke ? "R7 no extra done" : "R6 pulse", {31'd0, done}, 32'd0);
    check("R6 idle req", {31'd0, mem_req}, 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] afs [4];
    afs[0] = 20'h00000; afs[1] = 20'hFFFFF; afs[2] = 20'h5A3C1; afs[3] = 20'h80001;
    repeat (3) @(negedge clk);
    check("R1 done reset", {31'd0, done}, 32'd0);
    check("R1 req reset", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    for (int x = 0; x < 8; x++)
      for (int ind = 0; ind < 2; ind++)
        for (int a = 0; a < 4; a++) begin
          logic [31:0] xv;
          logic [31:0] rd;
          xv = 32'hC0000000 | (32'h2_4681 * (x + 1)) | (a == 1 ? 32'h1 : 32'h0);
          rd = {12'hABC, afs[a] ^ 20'h5A5A5} + x;
          run(afs[a], 3'(x), ind[0], xv, rd, (x + a) % 4, 1'b0);
        end
    run(20'h00100, 3'd3, 1'b1, 32'h000FFF00, 32'hFFF0BEEF, 2, 1'b1);
    run(20'h00200, 3'd0, 1'b0, 32'hFFFFFFFF, 32'h0, 0, 1'b1);
    run(20'hFFFF0, 3'd7, 1'b0, 32'h00000020, 32'h0, 0, 1'b0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule